// File: doc/BRIEF.md
# Fetch-Group Block-Level Branch Predictor

This block predicts where each instruction fetch group ends and where the following group starts. A group is addressed by its head PC. The head PC is the address of the first 16-bit parcel in the group. Each lookup reads one predictor entry. That entry describes the single branch that closes the group: the branch's parcel slot within the group, its taken target, and a 2-bit direction counter.

The group always stops at the recorded branch, whether that branch is predicted taken or not taken. As a result, a group holds at most one branch, and that branch is its last instruction. When no entry matches, the group runs to the full fetch width and the next head PC follows on sequentially.

The front end presents one head PC per cycle. One cycle later it receives the group length in parcels and the next head PC. Branch resolution later writes the outcome back through the update port. The update is keyed by the head PC of the group that contained the branch.

Top module: `fgp_predictor`

## Requirements
- R1: A lookup presented while `lookup_valid_i` is high produces `pred_valid_o` high exactly one clock later. With no lookup, `pred_valid_o` is low the next cycle and every other prediction output is zero.
- R2: The entry is selected by head-PC bits [6:1] (64 entries). A hit needs the entry valid and its stored tag equal to head-PC bits [31:7]. PC bit 0 has no effect on the result, and a PC with the same index but a different tag misses.
- R3: On a miss the outputs are `pred_hit_o`=0, `pred_taken_o`=0, `pred_len_o`=4, and `pred_next_pc_o` = head PC (bit 0 cleared) + 8.
- R4: On a hit with counter 0 or 1 (not taken), the outputs are `pred_len_o` = slot+1 and `pred_next_pc_o` = head PC + 2*(slot+1). This is the parcel just after the branch.
- R5: On a hit with counter 2 or 3 (taken), the outputs are `pred_taken_o`=1, `pred_len_o` = slot+1 and `pred_next_pc_o` = the stored target.
- R6: An update writes the entry at the head-PC index. It stores the tag, the slot and the target. Slot k (0..3) means the branch is the parcel at head+2k. When the entry did not already hold that tag, the counter starts at 2 if taken and at 1 if not taken.
- R7: An update to an entry that already holds the same tag moves the counter up by one when taken and down by one when not taken. The counter saturates at 3 and 0. Slot and target are overwritten.
- R8: Reset clears every entry, so that all lookups miss, and drives `pred_valid_o` low.
- R9: When a lookup and an update occur in the same cycle, the lookup sees the contents as they were before that update.
- R10: An update whose tag differs from the resident entry at the same index replaces that entry. The old head PC then misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_valid_i | input | 1 | Head PC is presented this cycle |
| lookup_pc_i | input | 32 | Head PC of the fetch group |
| pred_valid_o | output | 1 | Prediction for last cycle's lookup |
| pred_hit_o | output | 1 | An entry matched the head PC |
| pred_taken_o | output | 1 | The closing branch is predicted taken |
| pred_len_o | output | 3 | Group length in 16-bit parcels (1..4) |
| pred_next_pc_o | output | 32 | Head PC of the next group |
| upd_valid_i | input | 1 | Resolved branch write this cycle |
| upd_head_pc_i | input | 32 | Head PC of the group holding the branch |
| upd_slot_i | input | 2 | Parcel slot of the branch in its group |
| upd_taken_i | input | 1 | Resolved direction |
| upd_target_i | input | 32 | Resolved taken target |

## Verification
Every prediction output is due exactly one rising edge after the cycle in which its lookup is driven. An update changes what lookups see starting with the lookup driven in the cycle after the update, never in the same cycle. The bench therefore drives both ports on the falling edge and computes the expected result from its model before it applies that cycle's update to the model. It then compares all five outputs a quarter period after the following rising edge, on every cycle.

// File: rtl/fgp_pkg.sv
package fgp_pkg;
    localparam int FGP_PC_W    = 32;
    localparam int FGP_SLOTS   = 4;
    localparam int FGP_IDX_W   = 6;
    localparam int FGP_ENTRIES = 1 << FGP_IDX_W;
    localparam int FGP_SLOT_W  = $clog2(FGP_SLOTS);
    localparam int FGP_LEN_W   = $clog2(FGP_SLOTS + 1);
    localparam int FGP_TAG_W   = FGP_PC_W - FGP_IDX_W - 1;
    localparam int FGP_CTR_W   = 2;

    typedef struct packed {
        logic                  vld;
        logic [FGP_TAG_W-1:0]  tag;
        logic [FGP_SLOT_W-1:0] slot;
        logic [FGP_PC_W-1:0]   tgt;
        logic [FGP_CTR_W-1:0]  ctr;
    } fgp_entry_t;

    typedef struct packed {
        logic                  vld;
        logic                  hit;
        logic                  tkn;
        logic [FGP_LEN_W-1:0]  len;
        logic [FGP_PC_W-1:0]   nxt;
    } fgp_pred_t;
endpackage

// File: rtl/fgp_sat_ctr.sv
module fgp_sat_ctr
    import fgp_pkg::*;
(
    input  logic [FGP_CTR_W-1:0] ctr_i,
    input  logic                 taken_i,
    input  logic                 fresh_i,
    output logic [FGP_CTR_W-1:0] ctr_o
);
    localparam logic [FGP_CTR_W-1:0] CTR_MAX  = '1;
    localparam logic [FGP_CTR_W-1:0] CTR_WT   = FGP_CTR_W'(1) << (FGP_CTR_W - 1);
    localparam logic [FGP_CTR_W-1:0] CTR_WNT  = CTR_WT - FGP_CTR_W'(1);

    always_comb begin
        if (fresh_i) begin
            ctr_o = taken_i ? CTR_WT : CTR_WNT;
        end else if (taken_i) begin
            ctr_o = (ctr_i == CTR_MAX) ? ctr_i : ctr_i + FGP_CTR_W'(1);
        end else begin
            ctr_o = (ctr_i == '0) ? ctr_i : ctr_i - FGP_CTR_W'(1);
        end
    end
endmodule

// File: rtl/fgp_table.sv
module fgp_table
    import fgp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FGP_IDX_W-1:0]  rd_idx_i,
    output fgp_entry_t            rd_entry_o,
    input  logic                  upd_valid_i,
    input  logic [FGP_PC_W-1:0]   upd_pc_i,
    input  logic [FGP_SLOT_W-1:0] upd_slot_i,
    input  logic                  upd_taken_i,
    input  logic [FGP_PC_W-1:0]   upd_tgt_i
);
    typedef struct packed {
        fgp_entry_t [FGP_ENTRIES-1:0] ent;
    } fgp_tbl_t;

    fgp_tbl_t               tbl_d, tbl_q;
    logic [FGP_IDX_W-1:0]   upd_idx;
    logic [FGP_TAG_W-1:0]   upd_tag;
    fgp_entry_t             old_ent;
    logic                   upd_fresh;
    logic [FGP_CTR_W-1:0]   new_ctr;

    assign upd_idx   = FGP_IDX_W'(upd_pc_i >> 1);
    assign upd_tag   = FGP_TAG_W'(upd_pc_i >> (FGP_IDX_W + 1));
    assign old_ent   = tbl_q.ent[upd_idx];
    assign upd_fresh = !(old_ent.vld && (old_ent.tag == upd_tag));

    fgp_sat_ctr u_ctr (
        .ctr_i   (old_ent.ctr),
        .taken_i (upd_taken_i),
        .fresh_i (upd_fresh),
        .ctr_o   (new_ctr)
    );

    always_comb begin
        tbl_d = tbl_q;
        if (upd_valid_i) begin
            tbl_d.ent[upd_idx].vld  = 1'b1;
            tbl_d.ent[upd_idx].tag  = upd_tag;
            tbl_d.ent[upd_idx].slot = upd_slot_i;
            tbl_d.ent[upd_idx].tgt  = upd_tgt_i;
            tbl_d.ent[upd_idx].ctr  = new_ctr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    // read returns pre-update contents (R9)
    assign rd_entry_o = tbl_q.ent[rd_idx_i];

    p_upd_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_i |=> tbl_q.ent[$past(upd_idx)].vld &&
                        tbl_q.ent[$past(upd_idx)].tag == $past(upd_tag));

    p_ctr_top_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_i && !upd_fresh && upd_taken_i && old_ent.ctr == '1
        |=> tbl_q.ent[$past(upd_idx)].ctr == '1);

    p_ctr_low_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_i && !upd_fresh && !upd_taken_i && old_ent.ctr == '0
        |=> tbl_q.ent[$past(upd_idx)].ctr == '0);
endmodule

// File: rtl/fgp_resolve.sv
module fgp_resolve
    import fgp_pkg::*;
(
    input  logic [FGP_PC_W-1:0]  head_pc_i,
    input  fgp_entry_t           ent_i,
    output logic                 hit_o,
    output logic                 taken_o,
    output logic [FGP_LEN_W-1:0] len_o,
    output logic [FGP_PC_W-1:0]  next_pc_o
);
    logic [FGP_TAG_W-1:0] head_tag;

    assign head_tag = FGP_TAG_W'(head_pc_i >> (FGP_IDX_W + 1));

    always_comb begin
        hit_o   = ent_i.vld && (ent_i.tag == head_tag);
        taken_o = hit_o && ent_i.ctr[FGP_CTR_W-1];
        len_o   = hit_o ? FGP_LEN_W'(ent_i.slot) + FGP_LEN_W'(1)
                        : FGP_LEN_W'(FGP_SLOTS);
        if (taken_o) next_pc_o = ent_i.tgt;
        else         next_pc_o = head_pc_i + (FGP_PC_W'(len_o) << 1);
    end
endmodule

// File: rtl/fgp_predictor.sv
module fgp_predictor
    import fgp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lookup_valid_i,
    input  logic [FGP_PC_W-1:0]   lookup_pc_i,
    output logic                  pred_valid_o,
    output logic                  pred_hit_o,
    output logic                  pred_taken_o,
    output logic [FGP_LEN_W-1:0]  pred_len_o,
    output logic [FGP_PC_W-1:0]   pred_next_pc_o,
    input  logic                  upd_valid_i,
    input  logic [FGP_PC_W-1:0]   upd_head_pc_i,
    input  logic [FGP_SLOT_W-1:0] upd_slot_i,
    input  logic                  upd_taken_i,
    input  logic [FGP_PC_W-1:0]   upd_target_i
);
    fgp_pred_t             out_d, out_q;
    fgp_entry_t            rd_ent;
    logic [FGP_PC_W-1:0]   head_pc;
    logic                  r_hit, r_tkn;
    logic [FGP_LEN_W-1:0]  r_len;
    logic [FGP_PC_W-1:0]   r_nxt;

    assign head_pc = lookup_pc_i & ~FGP_PC_W'(1);

    fgp_table u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx_i    (FGP_IDX_W'(lookup_pc_i >> 1)),
        .rd_entry_o  (rd_ent),
        .upd_valid_i (upd_valid_i),
        .upd_pc_i    (upd_head_pc_i),
        .upd_slot_i  (upd_slot_i),
        .upd_taken_i (upd_taken_i),
        .upd_tgt_i   (upd_target_i)
    );

    fgp_resolve u_resolve (
        .head_pc_i (head_pc),
        .ent_i     (rd_ent),
        .hit_o     (r_hit),
        .taken_o   (r_tkn),
        .len_o     (r_len),
        .next_pc_o (r_nxt)
    );

    always_comb begin
        out_d = '0;
        if (lookup_valid_i) begin
            out_d.vld = 1'b1;
            out_d.hit = r_hit;
            out_d.tkn = r_tkn;
            out_d.len = r_len;
            out_d.nxt = r_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pred_valid_o   = out_q.vld;
    assign pred_hit_o     = out_q.hit;
    assign pred_taken_o   = out_q.tkn;
    assign pred_len_o     = out_q.len;
    assign pred_next_pc_o = out_q.nxt;

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid_i |=> pred_valid_o);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid_i |=> !pred_valid_o && !pred_hit_o && pred_len_o == '0);

    p_miss_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid_o && !pred_hit_o |-> pred_len_o == FGP_LEN_W'(FGP_SLOTS) && !pred_taken_o);

    p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid_o |-> pred_len_o >= FGP_LEN_W'(1) && pred_len_o <= FGP_LEN_W'(FGP_SLOTS));

    p_taken_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken_o |-> pred_hit_o && pred_valid_o);
endmodule

// File: tb/fgp_predictor_tb_top.sv
module fgp_predictor_tb_top;
    import fgp_pkg::*;

    logic clk = 1'b0;
    logic rst_n;
    always #10 clk = ~clk;

    logic                  lookup_valid_i;
    logic [FGP_PC_W-1:0]   lookup_pc_i;
    logic                  pred_valid_o, pred_hit_o, pred_taken_o;
    logic [FGP_LEN_W-1:0]  pred_len_o;
    logic [FGP_PC_W-1:0]   pred_next_pc_o;
    logic                  upd_valid_i;
    logic [FGP_PC_W-1:0]   upd_head_pc_i;
    logic [FGP_SLOT_W-1:0] upd_slot_i;
    logic                  upd_taken_i;
    logic [FGP_PC_W-1:0]   upd_target_i;

    fgp_predictor dut_i (.*);

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // behavioural reference
    bit          m_vld [FGP_ENTRIES];
    int unsigned m_tag [FGP_ENTRIES];
    int unsigned m_slot[FGP_ENTRIES];
    int unsigned m_tgt [FGP_ENTRIES];
    int          m_ctr [FGP_ENTRIES];

    int unsigned e_vld, e_hit, e_tkn, e_len, e_nxt;

    task automatic chk(string req, string what, int unsigned act, int unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cyc(string req, bit lv, int unsigned lpc,
                       bit uv, int unsigned upc, int unsigned uslot,
                       bit utkn, int unsigned utgt);
        int unsigned idx, tag;
        bit hit;
        @(negedge clk);
        lookup_valid_i = lv;   lookup_pc_i   = lpc;
        upd_valid_i    = uv;   upd_head_pc_i = upc;
        upd_slot_i     = FGP_SLOT_W'(uslot);
        upd_taken_i    = utkn; upd_target_i  = utgt;
        // expected lookup from contents before this cycle's update
        e_vld = 0; e_hit = 0; e_tkn = 0; e_len = 0; e_nxt = 0;
        if (lv) begin
            idx = (lpc >> 1) % FGP_ENTRIES;
            tag = lpc >> (FGP_IDX_W + 1);
            hit = m_vld[idx] && m_tag[idx] == tag;
            e_vld = 1;
            e_hit = hit;
            e_tkn = hit && m_ctr[idx] >= 2;
            e_len = hit ? m_slot[idx] + 1 : FGP_SLOTS;
            e_nxt = e_tkn ? m_tgt[idx] : (lpc & ~32'd1) + 2 * e_len;
        end
        if (uv) begin
            idx = (upc >> 1) % FGP_ENTRIES;
            tag = upc >> (FGP_IDX_W + 1);
            if (m_vld[idx] && m_tag[idx] == tag) begin
                if (utkn) m_ctr[idx] = (m_ctr[idx] < 3) ? m_ctr[idx] + 1 : 3;
                else      m_ctr[idx] = (m_ctr[idx] > 0) ? m_ctr[idx] - 1 : 0;
            end else begin
                m_ctr[idx] = utkn ? 2 : 1;
            end
            m_vld[idx] = 1; m_tag[idx] = tag; m_slot[idx] = uslot; m_tgt[idx] = utgt;
        end
        @(posedge clk);
        #5;
        chk(req, "valid",   pred_valid_o,   e_vld);
        chk(req, "hit",     pred_hit_o,     e_hit);
        chk(req, "taken",   pred_taken_o,   e_tkn);
        chk(req, "len",     pred_len_o,     e_len);
        chk(req, "next_pc", pred_next_pc_o, e_nxt);
    endtask

    task automatic look(string req, int unsigned pc);
        cyc(req, 1, pc, 0, 0, 0, 0, 0);
    endtask

    task automatic upd(string req, int unsigned pc, int unsigned slot, bit tkn, int unsigned tgt);
        cyc(req, 0, 0, 1, pc, slot, tkn, tgt);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned s;
        for (int i = 0; i < FGP_ENTRIES; i++) begin
            m_vld[i] = 0; m_tag[i] = 0; m_slot[i] = 0; m_tgt[i] = 0; m_ctr[i] = 0;
        end
        rst_n = 0; lookup_valid_i = 0; lookup_pc_i = 0; upd_valid_i = 0;
        upd_head_pc_i = 0; upd_slot_i = 0; upd_taken_i = 0; upd_target_i = 0;
        repeat (3) @(posedge clk);
        #5;
        chk("R8", "reset valid", pred_valid_o, 0);
        chk("R8", "reset hit",   pred_hit_o,   0);
        @(negedge clk);
        rst_n = 1;

        look("R8 R3 empty miss", 32'h5000);
        look("R3 miss odd",      32'h1236);
        cyc("R1 idle", 0, 32'h5000, 0, 0, 0, 0, 0);
        upd("R6 write nt",       32'h5000, 0, 0, 32'h6000);
        look("R4 one-parcel group", 32'h5000);
        look("R2 bit0 ignored",  32'h5001);
        upd("R6 write tk",       32'h5002, 2, 1, 32'h7000);
        look("R5 three-parcel taken", 32'h5002);
        cyc("R9 same-cycle", 1, 32'h5000, 1, 32'h5000, 0, 1, 32'h6000);
        look("R7 up to weak taken", 32'h5000);
        upd("R7 inc", 32'h5000, 0, 1, 32'h6000);
        upd("R7 inc sat", 32'h5000, 0, 1, 32'h6000);
        upd("R7 dec", 32'h5000, 0, 0, 32'h6000);
        look("R7 still taken", 32'h5000);
        upd("R7 dec", 32'h5000, 0, 0, 32'h6000);
        look("R7 now not taken", 32'h5000);
        upd("R7 dec", 32'h5000, 0, 0, 32'h6000);
        upd("R7 dec sat", 32'h5000, 0, 0, 32'h6000);
        upd("R7 inc from zero", 32'h5000, 3, 1, 32'h6100);
        look("R7 low bound", 32'h5000);
        look("R2 alias tag miss", 32'h5080);
        upd("R10 replace", 32'h5080, 1, 1, 32'h9000);
        look("R10 new resident", 32'h5080);
        look("R10 old evicted", 32'h5000);

        s = 32'h1234_5678;
        for (int i = 0; i < 400; i++) begin
            int unsigned pa, pb;
            s  = s * 1103515245 + 12345;
            pa = 32'h8000 + 2 * ((s >> 16) % 8) + 128 * ((s >> 20) % 2) + ((s >> 9) % 2);
            pb = 32'h8000 + 2 * ((s >> 24) % 8) + 128 * ((s >> 27) % 2);
            cyc("R2 R4 R5 R7 mix", (s >> 3) % 4 != 0, pa, (s >> 5) % 2,
                pb, (s >> 11) % FGP_SLOTS, (s >> 13) % 3 != 0, s & 32'hFFFE);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule